// File: doc/BRIEF.md
# Floating-point to saturating integer converter

This block turns a floating-point operand that has already been unpacked into class, sign, unbiased exponent and normalised mantissa into a signed two's-complement integer of `INT_W` bits. The default is 32 bits, and 64 bits is available through the parameter. The mantissa carries its leading one in the most significant bit and comes with a sticky bit for anything already shifted off below it. The block aligns the mantissa to the integer binary point and rounds in the selected mode. A control input can force truncation toward zero. Magnitudes that do not fit clamp to the largest integer of the operand's sign.

A result is computed in one pass of combinational logic and registered. It appears on the output one clock after `in_valid` is sampled high. Four flags come with every result: signalling-NaN seen, invalid conversion, inexact, and rounded away from truncation. When a conversion is invalid, its inexact and rounded flags are reported as zero.

Top module: `flt2int_sat`

## Requirements
- R1: Class code 0 (zero) yields a result of 0 with all four flags clear, whatever the sign, exponent and mantissa.
- R2: Class codes 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 all yield the most negative integer with `flag_invalid` set. `flag_snan` is set only for code 4.
- R3: Class code 2 (infinity), and class code 1 (number) with an exponent of `INT_W` or more, yield `2^(INT_W-1)-1` when the sign is 0 and `-2^(INT_W-1)` when the sign is 1, with `flag_invalid` set.
- R4: For class code 1, the operand's value is `in_mant * 2^(in_exp-(MANT_W-1))`, plus a nonzero remainder below the mantissa when `in_sticky` is 1. Negative exponents push the whole mantissa below the binary point, so the rounded magnitude is 0 or 1.
- R5: Mode 0 rounds to nearest. It increments the truncated magnitude when the discarded part exceeds one half, and on an exact half it increments only when the truncated magnitude is odd.
- R6: Mode 1 truncates. Mode 2 increments an inexact magnitude only for sign 0, and mode 3 does so only for sign 1.
- R7: With `force_rz` at 1, the block truncates whatever `rnd_mode` holds.
- R8: The rounded magnitude overflows when it is at least `2^(INT_W-1)` plus the sign bit. It then saturates by sign as in R3, with `flag_invalid` set. A negative operand of magnitude exactly `2^(INT_W-1)` converts without overflow.
- R9: `flag_inexact` is set when any discarded bit or the sticky bit is 1, and `flag_rnd_up` is set when the magnitude was incremented. Both are cleared whenever `flag_invalid` is set.
- R10: A negative result that does not overflow is the two's complement of the rounded magnitude.
- R11: Outputs are registered. `out_valid` equals the `in_valid` of the previous cycle, and the result and flags keep their values through cycles with `in_valid` low. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Operand class code (0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN) |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, leading one in the top bit |
| in_sticky | input | 1 | OR of mantissa bits already lost below `in_mant` |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| force_rz | input | 1 | Force truncation toward zero |
| out_valid | output | 1 | Result present |
| out_int | output | INT_W | Signed integer result |
| flag_snan | output | 1 | Signalling NaN operand |
| flag_invalid | output | 1 | Conversion out of range or not a number |
| flag_inexact | output | 1 | Discarded bits were nonzero |
| flag_rnd_up | output | 1 | Magnitude was incremented |

## Verification
Directed operands at exact halves, with even and odd integer parts, separate round-to-nearest-even from plain round-half-up. The same operands run under every mode, with and without the force input, to show that each mode moves the magnitude only for the sign it should. Operands just below and at `2^(INT_W-1)` in both signs, including one that reaches the limit only by rounding, show where the range check sits and that it is asymmetric. Randomised operands with exponents from far below zero to above `INT_W`, mixed classes and idle gaps are then compared cycle by cycle against an arithmetic model, which also covers the shift path and the held outputs.

// File: rtl/flt2int_pkg.sv
package flt2int_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fclass_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_e;

endpackage

// File: rtl/fti_align.sv
// Moves the mantissa so that the integer LSB sits just above MANT_W
// fraction bits. Bits shifted past the vector fold into the sticky term.
module fti_align #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 48,
    parameter int EXP_W  = 12
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic                    sticky_in,
    output logic [INT_W-1:0]        int_part,
    output logic                    guard,
    output logic                    rnd_sticky,
    output logic                    too_big
);
    localparam int W   = INT_W + MANT_W;
    localparam int SHW = $clog2(W + 1);
    localparam int XW  = EXP_W + 2;
    localparam logic signed [XW-1:0] RBASE = XW'(INT_W - 1);
    localparam logic signed [XW-1:0] WLIM  = XW'(W);

    logic signed [XW-1:0] exp_x;
    logic signed [XW-1:0] rsh_d;
    logic [SHW-1:0]       rsh;
    logic [W-1:0]         src;
    logic [W-1:0]         aligned;
    logic                 lost;

    always_comb begin
        exp_x   = XW'(exp_in);
        rsh_d   = RBASE - exp_x;
        too_big = (rsh_d < 0);
        rsh     = rsh_d[SHW-1:0];
        src     = {mant, {INT_W{1'b0}}};
        aligned = '0;
        lost    = 1'b0;
        if (too_big) begin
            aligned = '0;
            lost    = 1'b0;
        end else if (rsh_d >= WLIM) begin
            aligned = '0;
            lost    = |mant;
        end else begin
            aligned = src >> rsh;
            lost    = |(src << (W - int'(rsh)));
        end
    end

    assign int_part   = aligned[W-1:MANT_W];
    assign guard      = aligned[MANT_W-1];
    assign rnd_sticky = (|aligned[MANT_W-2:0]) | lost | sticky_in;

endmodule

// File: rtl/fti_round.sv
// Decides whether the truncated magnitude is incremented.
module fti_round
    import flt2int_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       force_rz,
    input  logic       sign,
    input  logic       guard,
    input  logic       rnd_sticky,
    input  logic       lsb,
    output logic       inc,
    output logic       inexact
);
    logic [1:0] eff_mode;

    always_comb begin
        inexact  = guard | rnd_sticky;
        eff_mode = force_rz ? RND_ZERO : mode;
        case (eff_mode)
            RND_NEAR: inc = guard & (rnd_sticky | lsb);
            RND_ZERO: inc = 1'b0;
            RND_POS:  inc = inexact & ~sign;
            default:  inc = inexact & sign;
        endcase
    end

endmodule

// File: rtl/fti_limit.sv
// Applies the increment, checks the sign-dependent range, negates.
module fti_limit #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] int_part,
    input  logic             inc,
    input  logic             sign,
    output logic             ovf,
    output logic [INT_W-1:0] value
);
    logic [INT_W:0] mag;
    logic [INT_W:0] limit;

    always_comb begin
        mag   = {1'b0, int_part} + {{INT_W{1'b0}}, inc};
        limit = {2'b01, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, sign};
        ovf   = (mag >= limit);
        value = sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
    end

endmodule

// File: rtl/flt2int_sat.sv
module flt2int_sat
    import flt2int_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int MANT_W = 48,
    parameter int EXP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_sticky,
    input  logic [1:0]              rnd_mode,
    input  logic                    force_rz,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int,
    output logic                    flag_snan,
    output logic                    flag_invalid,
    output logic                    flag_inexact,
    output logic                    flag_rnd_up
);
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] value;
        logic             snan;
        logic             invalid;
        logic             inexact;
        logic             rnd_up;
    } res_t;

    res_t st_d, st_q;

    logic [INT_W-1:0] int_part;
    logic             guard, rnd_sticky, too_big;
    logic             inc, inexact;
    logic             ovf;
    logic [INT_W-1:0] lim_value;

    fti_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .mant       (in_mant),
        .exp_in     (in_exp),
        .sticky_in  (in_sticky),
        .int_part   (int_part),
        .guard      (guard),
        .rnd_sticky (rnd_sticky),
        .too_big    (too_big)
    );

    fti_round u_round (
        .mode       (rnd_mode),
        .force_rz   (force_rz),
        .sign       (in_sign),
        .guard      (guard),
        .rnd_sticky (rnd_sticky),
        .lsb        (int_part[0]),
        .inc        (inc),
        .inexact    (inexact)
    );

    fti_limit #(.INT_W(INT_W)) u_limit (
        .int_part (int_part),
        .inc      (inc),
        .sign     (in_sign),
        .ovf      (ovf),
        .value    (lim_value)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.value   = '0;
            st_d.snan    = 1'b0;
            st_d.invalid = 1'b0;
            st_d.inexact = 1'b0;
            st_d.rnd_up  = 1'b0;
            if (in_class == CLS_ZERO) begin
                st_d.value = '0;
            end else if (in_class == CLS_NUM) begin
                if (too_big || ovf) begin
                    st_d.invalid = 1'b1;
                    st_d.value   = in_sign ? SAT_NEG : SAT_POS;
                end else begin
                    st_d.value   = lim_value;
                    st_d.inexact = inexact;
                    st_d.rnd_up  = inc;
                end
            end else if (in_class == CLS_INF) begin
                st_d.invalid = 1'b1;
                st_d.value   = in_sign ? SAT_NEG : SAT_POS;
            end else begin
                st_d.snan    = (in_class == CLS_SNAN);
                st_d.invalid = 1'b1;
                st_d.value   = SAT_NEG;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_int      = st_q.value;
    assign flag_snan    = st_q.snan;
    assign flag_invalid = st_q.invalid;
    assign flag_inexact = st_q.inexact;
    assign flag_rnd_up  = st_q.rnd_up;

endmodule

// File: rtl/flt2int_sat_chk.sv
module flt2int_sat_chk
    import flt2int_pkg::*;
#(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic             in_sign,
    input logic             force_rz,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             flag_snan,
    input logic             flag_invalid,
    input logic             flag_inexact,
    input logic             flag_rnd_up
);
    localparam logic [INT_W-1:0] MAXV = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MINV = {1'b1, {(INT_W-1){1'b0}}};

    p_zero_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == CLS_ZERO |=> out_int == '0 && !flag_snan
            && !flag_invalid && !flag_inexact && !flag_rnd_up);

    p_snan_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == CLS_SNAN |=> flag_snan && flag_invalid && out_int == MINV);

    p_inf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == CLS_INF |=> flag_invalid
            && out_int == ($past(in_sign) ? MINV : MAXV));

    p_force_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && force_rz |=> !flag_rnd_up);

    p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_invalid |-> !flag_inexact && !flag_rnd_up);

    p_rndup_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_rnd_up |-> flag_inexact);

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_int) && $stable(flag_invalid) && $stable(flag_inexact));

endmodule

bind flt2int_sat flt2int_sat_chk #(.INT_W(INT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .in_sign      (in_sign),
    .force_rz     (force_rz),
    .out_valid    (out_valid),
    .out_int      (out_int),
    .flag_snan    (flag_snan),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .flag_rnd_up  (flag_rnd_up)
);

// File: tb/test_flt2int_sat.sv
module test_flt2int_sat;
    localparam int INT_W  = 32;
    localparam int MANT_W = 48;
    localparam int EXP_W  = 12;
    localparam logic [31:0] MAXV = 32'h7FFF_FFFF;
    localparam logic [31:0] MINV = 32'h8000_0000;
    localparam logic [47:0] ONE  = 48'h8000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_class = '0;
    logic in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic in_sticky = 1'b0;
    logic [1:0] rnd_mode = '0;
    logic force_rz = 1'b0;
    logic out_valid;
    logic [INT_W-1:0] out_int;
    logic flag_snan, flag_invalid, flag_inexact, flag_rnd_up;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic e_valid = 1'b0;
    logic [31:0] e_int = '0;
    logic e_snan = 1'b0, e_inv = 1'b0, e_inx = 1'b0, e_up = 1'b0;
    bit pending = 1'b0;
    string pend_tag = "";

    always #10 clk = ~clk;

    flt2int_sat #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_flt2int_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
        .rnd_mode(rnd_mode), .force_rz(force_rz), .out_valid(out_valid), .out_int(out_int),
        .flag_snan(flag_snan), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .flag_rnd_up(flag_rnd_up)
    );

    task automatic model(input logic [2:0] cls, input logic sg, input int ex,
                         input logic [47:0] mt, input logic stk, input logic [1:0] md,
                         input logic frz, output logic [31:0] r, output logic sn,
                         output logic inv, output logic inx, output logic up);
        logic [127:0] ip, rem, half, mag, lim;
        logic above, tie;
        int sh;
        r = '0; sn = 0; inv = 0; inx = 0; up = 0;
        if (cls == 3'd0) begin
            r = '0;
        end else if (cls >= 3'd3) begin
            sn = (cls == 3'd4); inv = 1; r = MINV;
        end else if (cls == 3'd2 || ex >= 32) begin
            inv = 1; r = sg ? MINV : MAXV;
        end else begin
            sh = 47 - ex;
            above = 0; tie = 0;
            if (sh <= 0) begin
                ip = {80'd0, mt} << (-sh); rem = '0;
            end else if (sh > 120) begin
                ip = '0; rem = {80'd0, mt};
            end else begin
                ip   = {80'd0, mt} >> sh;
                rem  = {80'd0, mt} - (ip << sh);
                half = 128'd1 << (sh - 1);
                above = (rem > half) || (rem == half && stk);
                tie   = (rem == half) && !stk;
            end
            inx = (rem != 0) || stk;
            case (frz ? 2'd1 : md)
                2'd0: up = above || (tie && ip[0]);
                2'd1: up = 0;
                2'd2: up = inx && !sg;
                default: up = inx && sg;
            endcase
            mag = ip + {127'd0, up};
            lim = (128'd1 << 31) + {127'd0, sg};
            if (mag >= lim) begin
                inv = 1; inx = 0; up = 0; r = sg ? MINV : MAXV;
            end else begin
                r = sg ? (~mag[31:0] + 32'd1) : mag[31:0];
            end
        end
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (out_valid !== e_valid || out_int !== e_int || flag_snan !== e_snan ||
            flag_invalid !== e_inv || flag_inexact !== e_inx || flag_rnd_up !== e_up) begin
            n_fail++;
            $display("FAIL %s: got v=%b int=%h sn=%b inv=%b inx=%b up=%b, expected v=%b int=%h sn=%b inv=%b inx=%b up=%b",
                     tag, out_valid, out_int, flag_snan, flag_invalid, flag_inexact, flag_rnd_up,
                     e_valid, e_int, e_snan, e_inv, e_inx, e_up);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] cls, input logic sg, input int ex,
                         input logic [47:0] mt, input logic stk, input logic [1:0] md,
                         input logic frz, input string tag);
        logic [31:0] r;
        logic sn, inv, inx, up;
        @(negedge clk);
        if (pending) compare(pend_tag);
        in_valid = v; in_class = cls; in_sign = sg; in_exp = EXP_W'(ex);
        in_mant = mt; in_sticky = stk; rnd_mode = md; force_rz = frz;
        e_valid = v;
        if (v) begin
            model(cls, sg, ex, mt, stk, md, frz, r, sn, inv, inx, up);
            e_int = r; e_snan = sn; e_inv = inv; e_inx = inx; e_up = up;
        end
        pending = 1'b1;
        pend_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R11 reset");
        rst_n = 1'b1;
        // R1 zero, even with nonzero mantissa and sticky
        apply(1, 3'd0, 1, 5, 48'hFFFF_0000_1234, 1, 2'd3, 0, "R1 zero");
        // R4 alignment of exact values
        apply(1, 3'd1, 0, 0, ONE, 0, 2'd0, 0, "R4 one");
        apply(1, 3'd1, 0, 3, 48'hA000_0000_0000, 0, 2'd0, 0, "R4 ten");
        apply(1, 3'd1, 0, -1, 48'hC000_0000_0000, 0, 2'd0, 0, "R4 0.75 to 1");
        apply(1, 3'd1, 0, -100, ONE, 0, 2'd2, 0, "R4 tiny up");
        apply(1, 3'd1, 1, -100, ONE, 0, 2'd0, 0, "R4 tiny zero");
        // R5 nearest even: 1.5 -> 2, 2.5 -> 2, 0.5 -> 0, 2.5+sticky -> 3
        apply(1, 3'd1, 0, 0, 48'hC000_0000_0000, 0, 2'd0, 0, "R5 1.5");
        apply(1, 3'd1, 0, 1, 48'hA000_0000_0000, 0, 2'd0, 0, "R5 2.5");
        apply(1, 3'd1, 0, -1, ONE, 0, 2'd0, 0, "R5 0.5");
        apply(1, 3'd1, 0, 1, 48'hA000_0000_0000, 1, 2'd0, 0, "R5 2.5 sticky");
        // R6 directed modes on +-2.5
        apply(1, 3'd1, 1, 1, 48'hA000_0000_0000, 0, 2'd1, 0, "R6 rz neg");
        apply(1, 3'd1, 0, 1, 48'hA000_0000_0000, 0, 2'd2, 0, "R6 rp pos");
        apply(1, 3'd1, 1, 1, 48'hA000_0000_0000, 0, 2'd2, 0, "R6 rp neg");
        apply(1, 3'd1, 1, 1, 48'hA000_0000_0000, 0, 2'd3, 0, "R6 rm neg");
        apply(1, 3'd1, 0, 1, 48'hA000_0000_0000, 0, 2'd3, 0, "R6 rm pos");
        // R7 force toward zero on 2.75
        apply(1, 3'd1, 0, 1, 48'hB000_0000_0000, 0, 2'd0, 1, "R7 force rz");
        apply(1, 3'd1, 1, 1, 48'hB000_0000_0000, 0, 2'd3, 1, "R7 force rz neg");
        // R8 range edges
        apply(1, 3'd1, 0, 31, ONE, 0, 2'd0, 0, "R8 pos 2^31");
        apply(1, 3'd1, 1, 31, ONE, 0, 2'd0, 0, "R8 neg 2^31");
        apply(1, 3'd1, 0, 30, 48'hFFFF_FFFF_FFFF, 0, 2'd0, 0, "R8 round into ovf");
        apply(1, 3'd1, 0, 30, 48'hFFFF_FFFF_FFFF, 0, 2'd1, 0, "R8 max pos");
        apply(1, 3'd1, 1, 31, 48'h8000_0000_8000, 0, 2'd1, 0, "R8 neg just over");
        // R3 infinity and large exponent
        apply(1, 3'd1, 0, 32, ONE, 0, 2'd0, 0, "R3 exp 32");
        apply(1, 3'd2, 1, 0, '0, 0, 2'd0, 0, "R3 neg inf");
        apply(1, 3'd2, 0, 0, '0, 0, 2'd0, 0, "R3 pos inf");
        // R2 NaNs
        apply(1, 3'd4, 0, 0, ONE, 0, 2'd0, 0, "R2 snan");
        apply(1, 3'd3, 0, 0, ONE, 0, 2'd0, 0, "R2 qnan");
        apply(1, 3'd6, 0, 0, ONE, 0, 2'd0, 0, "R2 reserved");
        // R10 negatives and R9 flags
        apply(1, 3'd1, 1, 2, 48'hA000_0000_0000, 0, 2'd0, 0, "R10 minus five");
        apply(1, 3'd1, 1, 0, 48'hE000_0000_0000, 0, 2'd0, 0, "R9 R10 -1.75");
        // R11 hold through idle cycles with changing inputs
        apply(0, 3'd2, 1, 40, 48'h1234_5678_9ABC, 1, 2'd3, 1, "R11 idle");
        apply(0, 3'd0, 0, 1, 48'h0, 0, 2'd0, 0, "R11 idle2");
        for (int k = 0; k < 600; k++) begin
            int sel;
            logic [2:0] c;
            int ex;
            sel = int'($urandom % 16);
            if (sel == 0) c = 3'd0;
            else if (sel == 1) c = 3'd2;
            else if (sel == 2) c = 3'd3;
            else if (sel == 3) c = 3'd4;
            else if (sel == 4) c = 3'(5 + $urandom % 3);
            else c = 3'd1;
            ex = ($urandom % 10 == 0) ? -300 : int'($urandom % 44) - 8;
            apply(($urandom % 6) != 0, c, 1'($urandom), ex,
                  {1'b1, 15'($urandom), 32'($urandom)}, 1'($urandom),
                  2'($urandom), ($urandom % 8) == 0, "R4 R5 R6 R8 random");
        end
        apply(0, 3'd0, 0, 0, '0, 0, 2'd0, 0, "R11 flush");
        @(negedge clk);
        compare("R11 flush");
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule